// File: doc/BRIEF.md
# Performance monitor counter unit

A bank of hardware performance counters for a processor core. It holds one free-running cycle counter and four event counters. Each event counter watches one line of an event-pulse vector, and an 8-bit code picks that line. Event sources raise single-cycle pulses, and a counter that has been set up advances once for every pulse on its selected line.

Software drives the unit through a small word-addressed register port. Writes take effect at the next clock edge. Read data is combinational on the address. Any counter can be written, so software can preload a counter with the two's complement of a sampling period. After exactly that many events the counter wraps. A wrap sets a sticky per-counter flag, and the flag raises a level interrupt if that counter's enable bit is set. Software clears a flag by writing a one to its bit.

The control word holds three things: a global run bit, two self-clearing reset strobes, and an option that slows the cycle counter to one step per 64 clocks.

Top module: `perfmon_bank`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: While the run bit (control bit 0) is clear, no counter changes unless software writes it.
- R3: While running with control bit 3 clear, the cycle counter (address 0x04) advances by one on every clock edge.
- R4: While running with control bit 3 set, the cycle counter advances once every 64 clock edges. The count is measured from the edge that cleared it.
- R5: An event counter advances on each edge where the run bit is set and the `evt_pulse` bit indexed by its code is high. A code of 0xFF, or any code of 32 or more, never advances it.
- R6: The event-select word at 0x10 holds the codes for event counters 0, 1, 2 and 3 in bits 7:0, 15:8, 23:16 and 31:24. Event counter k sits at address 0x14 + 4k.
- R7: Writing 1 to control bit 1 clears all event counters. Writing 1 to control bit 2 clears the cycle counter and its divide-by-64 phase. Neither bit is stored: control reads return zero in bits 1 and 2.
- R8: Every counter can be read back and written. A counter preloaded with -N wraps to zero on exactly the Nth counted step.
- R9: A wrap from all-ones to zero sets the counter's flag in the overflow word at 0x0C on the same edge. Bit 0 is the cycle counter and bits 1 to 4 are event counters 0 to 3. A flag stays set through further wraps.
- R10: Writing the overflow word clears each flag whose data bit is 1. Data bits that are 0 leave their flags as they are.
- R11: `irq` is a register that goes high one edge after any flag and its matching enable bit at 0x08 (same bit layout) are both set. It goes low one edge after no such pair remains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 6 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_pulse | input | 32 | One-cycle event pulses, indexed by event code |
| irq | output | 1 | Level interrupt for enabled overflows |

## Verification
Read data is combinational, so the bench samples it 1 ns after the address settles, with no edge in between. Everything a write or an event pulse causes lands on the next rising edge. That covers counter values, flag sets and clears, and the reset strobes, and the bench reads them 1 ns after that edge. `irq` is registered from the flags and enables, so it lags them by exactly one more edge. The bench checks it once right after the edge that changes the flags, where it must still hold the old value, and again after the following edge. In the counting sweeps the expected cycle count comes from the number of edges since the clearing write, divided by 64 in the slow mode. The expected event counts are the popcount of the selected bit over the pulse patterns applied.

// File: rtl/perfmon_bank.sv
`timescale 1ns/1ps
module perfmon_bank #(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 32,
  parameter int CODE_W  = 8,
  parameter int PRE_DIV = 64,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_EVT-1:0] evt_pulse,
  output logic              irq
);
  localparam int NUM_CTR = 4;
  localparam int NFLG    = NUM_CTR + 1;
  localparam int PRE_W   = $clog2(PRE_DIV);
  localparam int IDX_W   = $clog2(NUM_EVT);
  localparam int SEL_W   = NUM_CTR * CODE_W;
  localparam int WORD_W  = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_CTRL = 0, W_CCNT = 1, W_IE = 2, W_OVF = 3, W_SEL = 4, W_PMN0 = 5;

  logic                            ctrl_en_q, ctrl_div_q;
  logic [PRE_W-1:0]                pre_q;
  logic [CNT_W-1:0]                ccnt_q;
  logic [NFLG-1:0]                 ie_q, ovf_q, wrap;
  logic [SEL_W-1:0]                sel_q;
  logic [NUM_CTR-1:0][CNT_W-1:0]   pmn_q;
  logic                            irq_q;

  logic [WORD_W-1:0] word;
  logic unused_lsb;
  assign word       = reg_addr[ADDR_W-1:2];
  assign unused_lsb = ^reg_addr[1:0];

  logic wr_ctrl, wr_ccnt, rst_evt, rst_cyc, pre_end, cyc_tick;
  assign wr_ctrl  = reg_wr && word == W_CTRL;
  assign wr_ccnt  = reg_wr && word == W_CCNT;
  assign rst_evt  = wr_ctrl && reg_wdata[1];
  assign rst_cyc  = wr_ctrl && reg_wdata[2];
  assign pre_end  = pre_q == PRE_W'(PRE_DIV - 1);
  assign cyc_tick = ctrl_en_q && (!ctrl_div_q || pre_end);
  assign wrap[0]  = cyc_tick && (&ccnt_q) && !rst_cyc && !wr_ccnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en_q  <= 1'b0;
      ctrl_div_q <= 1'b0;
      ie_q       <= '0;
      sel_q      <= '0;
    end else if (reg_wr) begin
      if (word == W_CTRL) begin
        ctrl_en_q  <= reg_wdata[0];
        ctrl_div_q <= reg_wdata[3];
      end
      if (word == W_IE)  ie_q  <= reg_wdata[NFLG-1:0];
      if (word == W_SEL) sel_q <= reg_wdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pre_q <= '0;
    else if (rst_cyc)                pre_q <= '0;
    else if (ctrl_en_q && ctrl_div_q) pre_q <= pre_end ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ccnt_q <= '0;
    else if (rst_cyc)  ccnt_q <= '0;
    else if (wr_ccnt)  ccnt_q <= reg_wdata[CNT_W-1:0];
    else if (cyc_tick) ccnt_q <= ccnt_q + 1'b1;
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_evt
    logic [CODE_W-1:0] code;
    logic              valid, hit, wr_me;
    assign code  = sel_q[i*CODE_W +: CODE_W];
    assign valid = 32'(code) < NUM_EVT;
    assign hit   = ctrl_en_q && valid && evt_pulse[code[IDX_W-1:0]];
    assign wr_me = reg_wr && word == W_PMN0 + WORD_W'(i);
    assign wrap[i+1] = hit && (&pmn_q[i]) && !rst_evt && !wr_me;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pmn_q[i] <= '0;
      else if (rst_evt) pmn_q[i] <= '0;
      else if (wr_me)   pmn_q[i] <= reg_wdata[CNT_W-1:0];
      else if (hit)     pmn_q[i] <= pmn_q[i] + 1'b1;
    end
  end

  logic [NFLG-1:0] clr;
  assign clr = (reg_wr && word == W_OVF) ? reg_wdata[NFLG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= '0;
      irq_q <= 1'b0;
    end else begin
      ovf_q <= (ovf_q & ~clr) | wrap;
      irq_q <= |(ovf_q & ie_q);
    end
  end
  assign irq = irq_q;

  always_comb begin
    reg_rdata = '0;
    case (word)
      W_CTRL:  reg_rdata = {28'd0, ctrl_div_q, 2'b00, ctrl_en_q};
      W_CCNT:  reg_rdata = 32'(ccnt_q);
      W_IE:    reg_rdata = 32'(ie_q);
      W_OVF:   reg_rdata = 32'(ovf_q);
      W_SEL:   reg_rdata = 32'(sel_q);
      default: begin
        for (int k = 0; k < NUM_CTR; k++)
          if (word == W_PMN0 + WORD_W'(k)) reg_rdata = 32'(pmn_q[k]);
      end
    endcase
  end
endmodule

// File: rtl/perfmon_bank_chk.sv
`timescale 1ns/1ps
module perfmon_bank_chk #(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 32,
  parameter int CODE_W  = 8,
  parameter int ADDR_W  = 6,
  parameter int NUM_CTR = 4,
  parameter int NFLG    = 5
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_wr,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [31:0]                   reg_rdata,
  input logic                          irq,
  input logic                          en,
  input logic                          div,
  input logic [CNT_W-1:0]              ccnt,
  input logic [NFLG-1:0]               ovf,
  input logic [NFLG-1:0]               ie,
  input logic [NUM_CTR*CODE_W-1:0]     sel,
  input logic [NUM_CTR-1:0][CNT_W-1:0] pmn
);
  logic ovf_write;
  assign ovf_write = reg_wr && reg_addr[ADDR_W-1:2] == 3;

  AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !reg_wr) |=> ($stable(ccnt) && $stable(pmn))); // R2
  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !div && !reg_wr) |=> ccnt == $past(ccnt) + CNT_W'(1)); // R3
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[CODE_W-1:0] == 8'hFF && !reg_wr) |=> $stable(pmn[0])); // R5
  AST_CTRL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[ADDR_W-1:2] == 0) |-> reg_rdata[2:1] == 2'b00); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_write |=> (ovf & $past(ovf)) == $past(ovf)); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf & ie) == '0) |=> !irq); // R11
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((ovf & ie) != '0)); // R11
endmodule

bind perfmon_bank perfmon_bank_chk #(
  .CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .CODE_W(CODE_W), .ADDR_W(ADDR_W),
  .NUM_CTR(NUM_CTR), .NFLG(NFLG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .irq(irq), .en(ctrl_en_q), .div(ctrl_div_q),
  .ccnt(ccnt_q), .ovf(ovf_q), .ie(ie_q), .sel(sel_q), .pmn(pmn_q)
);

// File: tb/perfmon_bank_tb.sv
`timescale 1ns/1ps
module perfmon_bank_tb;
  logic        clk = 0, rst_n = 0, reg_wr = 0;
  logic [5:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, evt_pulse = 0;
  logic        irq;
  int checks = 0, errors = 0;

  perfmon_bank u_dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse), .irq(irq));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input logic [31:0] m);
    @(negedge clk); evt_pulse = m;
    @(posedge clk); #1; evt_pulse = 0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, x;
    logic [7:0]  codes [4];
    int          exp_cnt [4];
    int          t;
    #20 rst_n = 1;
    step(1);

    for (int a = 0; a < 9; a++) begin
      rd(6'(a * 4), v); chk("R1 reset register", v, 0);
    end
    chk("R1 reset irq", 32'(irq), 0);

    wr(6'h10, 32'h03020100);
    @(negedge clk); evt_pulse = '1;
    step(20);
    evt_pulse = 0;
    rd(6'h04, v); chk("R2 cycle counter frozen", v, 0);
    for (int k = 0; k < 4; k++) begin
      rd(6'(8'h14 + 4 * k), v); chk("R2 event counter frozen", v, 0);
    end

    wr(6'h00, 32'h5);
    rd(6'h04, v); chk("R3 cleared at start", v, 0);
    t = 0;
    for (int s = 1; s < 40; s += 7) begin
      step(s); t += s;
      rd(6'h04, v); chk("R3 cycle count", v, 32'(t));
    end

    wr(6'h00, 32'hD);
    t = 0;
    foreach (codes[i]) codes[i] = 0;
    for (int s = 0; s < 6; s++) begin
      int inc;
      inc = (s == 0) ? 63 : (s == 1) ? 1 : (s == 2) ? 63 : (s == 3) ? 1 : (s == 4) ? 72 : 300;
      step(inc); t += inc;
      rd(6'h04, v); chk("R4 divided cycle count", v, 32'(t / 64));
    end

    x = 32'h1234_5678;
    for (int round = 0; round < 3; round++) begin
      case (round)
        0: begin codes[0] = 8'h00; codes[1] = 8'h05; codes[2] = 8'h07; codes[3] = 8'h1F; end
        1: begin codes[0] = 8'hFF; codes[1] = 8'h0C; codes[2] = 8'h20; codes[3] = 8'h03; end
        default: begin codes[0] = 8'h11; codes[1] = 8'h11; codes[2] = 8'h1E; codes[3] = 8'hFF; end
      endcase
      wr(6'h00, 32'h6);
      wr(6'h10, {codes[3], codes[2], codes[1], codes[0]});
      rd(6'h10, v); chk("R6 event select readback", v, {codes[3], codes[2], codes[1], codes[0]});
      foreach (exp_cnt[i]) exp_cnt[i] = 0;
      wr(6'h00, 32'h1);
      for (int j = 0; j < 150; j++) begin
        x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
        @(negedge clk); evt_pulse = x;
        for (int k = 0; k < 4; k++)
          if (codes[k] < 32 && x[codes[k][4:0]]) exp_cnt[k]++;
      end
      @(negedge clk); evt_pulse = 0;
      wr(6'h00, 32'h0);
      for (int k = 0; k < 4; k++) begin
        rd(6'(8'h14 + 4 * k), v); chk("R5 R6 event count", v, 32'(exp_cnt[k]));
      end
    end

    wr(6'h10, 32'h0000_0007);
    wr(6'h00, 32'h1);
    pulse(32'h80); pulse(32'h80);
    rd(6'h04, x);
    wr(6'h00, 32'h3);
    rd(6'h14, v); chk("R7 event counters cleared", v, 0);
    rd(6'h04, v); chk("R7 cycle counter untouched", 32'(v != 0), 1);
    rd(6'h00, v); chk("R7 control read hides strobes", v, 32'h1);
    wr(6'h00, 32'h5);
    rd(6'h04, v); chk("R7 cycle counter cleared", v, 0);
    rd(6'h00, v); chk("R7 control read after cycle strobe", v, 32'h1);

    wr(6'h00, 32'h0);
    wr(6'h10, 32'hFFFF_FF07);
    wr(6'h14, 32'hFFFF_FFFB);
    rd(6'h14, v); chk("R8 preload readback", v, 32'hFFFF_FFFB);
    wr(6'h08, 32'h02);
    wr(6'h0C, 32'h1F);
    wr(6'h00, 32'h1);
    for (int n = 0; n < 4; n++) pulse(32'h80);
    rd(6'h14, v); chk("R8 before wrap", v, 32'hFFFF_FFFF);
    rd(6'h0C, v); chk("R9 no flag before wrap", v, 0);
    pulse(32'h80);
    rd(6'h14, v); chk("R8 wrapped on fifth event", v, 0);
    rd(6'h0C, v); chk("R9 flag on wrap edge", v, 32'h02);
    chk("R11 irq not yet", 32'(irq), 0);
    step(1);
    chk("R11 irq one edge later", 32'(irq), 1);

    wr(6'h00, 32'h0);
    wr(6'h04, 32'hFFFF_FFFF);
    wr(6'h00, 32'h1);
    rd(6'h04, v); chk("R8 cycle preload", v, 32'hFFFF_FFFF);
    step(1);
    rd(6'h04, v); chk("R9 cycle wrap", v, 0);
    rd(6'h0C, v); chk("R9 cycle flag bit 0", v, 32'h03);
    wr(6'h04, 32'hFFFF_FFFF);
    step(1);
    rd(6'h0C, v); chk("R9 sticky over second wrap", v, 32'h03);
    wr(6'h0C, 32'h0);
    rd(6'h0C, v); chk("R10 zero write keeps flags", v, 32'h03);
    wr(6'h0C, 32'h2);
    rd(6'h0C, v); chk("R10 one clears only its flag", v, 32'h01);
    chk("R11 irq still old value", 32'(irq), 1);
    step(1);
    chk("R11 irq drops, bit 0 masked", 32'(irq), 0);
    wr(6'h08, 32'h03);
    chk("R11 irq lags enable", 32'(irq), 0);
    step(1);
    chk("R11 irq rises for enabled flag", 32'(irq), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule